// File: doc/BRIEF.md
# Semaphore Bank Command Unit

This block keeps a bank of small counting semaphores and executes the 32-bit semaphore command words that accompany transfer requests. A request sequencer presents one command word at a time on a valid/ready port. The block decodes the word, applies the selected operation to one semaphore and raises ready. Ready means the command has finished. For a wait-type command, ready means the wait condition holds right now.

A second, workload-side port lets the compute side raise or lower any semaphore by one. This is how blocked waits get released. Both ports may hit the same semaphore in the same cycle, and neither update is lost. A third, registered read port returns the value of any semaphore.

Every command word carries a phase selector. The sequencer states whether it is currently in the phase before the data move or the phase after it. A word tagged for the other phase is passed over without effect.

Top module: `sem_bank_cmd`

## Requirements
- R1: After reset every semaphore reads zero and `cmd_err` is low.
- R2: A word with bit 31 clear is acknowledged (`cmd_ready` high in the same cycle as `cmd_valid`) and changes no semaphore.
- R3: Bit 22 tags a word for the pre-move phase (1) or post-move phase (0). When the tag differs from `cmd_phase_pre`, the word is acknowledged at once and has no effect.
- R4: Bits 26:24 hold the opcode and bits 20:16 the semaphore number. Opcode 1 loads bits 11:0 into that semaphore.
- R5: Opcode 2 adds one and opcode 3 subtracts one, both modulo 4096 (4095+1 gives 0, 0-1 gives 4095).
- R6: Opcode 4 is acknowledged only while the semaphore equals bits 11:0, and it leaves the semaphore unchanged.
- R7: Opcode 5 is acknowledged only while the semaphore is greater than or equal to bits 11:0.
- R8: Opcode 6 is acknowledged only while the semaphore is non-zero. In the same handshake cycle it subtracts one, so a count of zero is never taken.
- R9: Opcode 7 is acknowledged at once and changes nothing. `cmd_err` is high for exactly the one cycle after that handshake. Opcode 0 is acknowledged with no change and no error.
- R10: A `wl_valid` cycle adds one to semaphore `wl_idx`, or subtracts one when `wl_down` is 1, modulo 4096.
- R11: When a command update and a workload update target the same semaphore in one cycle, both are applied. A load takes the operand plus the workload step.
- R12: `rd_value` is registered: it shows the value that semaphore `rd_idx` held at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 32 | Semaphore command word |
| cmd_phase_pre | input | 1 | Sequencer is in the pre-move phase |
| cmd_ready | output | 1 | Command complete or its wait condition met |
| cmd_err | output | 1 | One-cycle pulse after a reserved opcode is accepted |
| wl_valid | input | 1 | Workload step request |
| wl_idx | input | 5 | Semaphore stepped by the workload |
| wl_down | input | 1 | 1 subtracts one, 0 adds one |
| rd_idx | input | 5 | Semaphore to read |
| rd_value | output | 12 | Registered read data |

## Verification
The command port and the workload port can update the same semaphore in one clock cycle. The bench provokes this by driving both ports at one negative edge with matching indices. It covers three pairings: a load with a workload increment, an increment with an increment, and an atomic take with an increment. Each result is judged through the read port against the sum of both effects. The bench also releases waits and takes by stepping through the workload port. It checks that ready stays low until the cycle after the step lands.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LOAD = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_RSV  = 3'd7
  } sem_op_e;

  localparam int WORD_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int OP_LSB  = 24;
  localparam int PRE_BIT = 22;
  localparam int IDX_LSB = 16;

endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
  import sbu_pkg::*;
#(
  parameter int IW = 5,
  parameter int VW = 12
) (
  input  logic [WORD_W-1:0] word,
  input  logic              phase_pre,
  output logic              active,
  output sem_op_e           op,
  output logic [IW-1:0]     idx,
  output logic [VW-1:0]     val
);
  // A word acts only when it is enabled and tagged for the current phase.
  assign active = word[EN_BIT] && (word[PRE_BIT] == phase_pre);
  assign op     = sem_op_e'(word[OP_LSB +: 3]);
  assign idx    = word[IDX_LSB +: IW];
  assign val    = word[VW-1:0];
endmodule

// File: rtl/sbu_eval.sv
module sbu_eval
  import sbu_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          valid,
  input  logic          active,
  input  sem_op_e       op,
  input  logic [VW-1:0] cur,
  input  logic [VW-1:0] val,
  output logic          ready,
  output logic          apply,
  output logic          load,
  output logic [VW-1:0] delta,
  output logic          err
);
  localparam logic [VW-1:0] STEP_UP   = VW'(1);
  localparam logic [VW-1:0] STEP_DOWN = '1;

  logic cond;
  logic [VW-1:0] d;
  logic ld;

  always_comb begin
    cond = 1'b1;
    d    = '0;
    ld   = 1'b0;
    if (active) begin
      unique case (op)
        OP_LOAD: ld = 1'b1;
        OP_INC:  d  = STEP_UP;
        OP_DEC:  d  = STEP_DOWN;
        OP_WEQ:  cond = (cur == val);
        OP_WGE:  cond = (cur >= val);
        OP_TAKE: begin
          cond = (cur != '0);
          d    = STEP_DOWN;
        end
        default: ;
      endcase
    end
  end

  assign ready = valid && cond;
  assign apply = ready && active && (ld || d != '0);
  assign load  = ld;
  assign delta = d;
  assign err   = ready && active && (op == OP_RSV);
endmodule

// File: rtl/sbu_store.sv
module sbu_store #(
  parameter int NSEM = 32,
  parameter int VW   = 12,
  localparam int IW  = $clog2(NSEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               c_apply,
  input  logic [IW-1:0]      c_idx,
  input  logic               c_load,
  input  logic [VW-1:0]      c_val,
  input  logic [VW-1:0]      c_delta,
  input  logic               w_valid,
  input  logic [IW-1:0]      w_idx,
  input  logic               w_down,
  input  logic [IW-1:0]      rd_idx,
  output logic [VW-1:0]      c_cur,
  output logic [NSEM*VW-1:0] sem_flat,
  output logic [VW-1:0]      rd_value
);
  logic [VW-1:0] sem [NSEM];
  logic [VW-1:0] w_step;

  assign w_step = w_down ? '1 : VW'(1);

  for (genvar i = 0; i < NSEM; i++) begin : g_ent
    logic [VW-1:0] q;
    logic [VW-1:0] base;
    logic [VW-1:0] add_c;
    logic [VW-1:0] add_w;
    logic          hit_c;
    logic          hit_w;

    assign hit_c = c_apply && (c_idx == IW'(i));
    assign hit_w = w_valid && (w_idx == IW'(i));
    assign base  = (hit_c && c_load) ? c_val : q;
    assign add_c = hit_c ? c_delta : '0;
    assign add_w = hit_w ? w_step : '0;

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (hit_c || hit_w) q <= base + add_c + add_w;
    end

    assign sem[i] = q;
    assign sem_flat[i*VW +: VW] = q;
  end

  assign c_cur = sem[c_idx];

  always_ff @(posedge clk) begin
    if (rst) rd_value <= '0;
    else     rd_value <= sem[rd_idx];
  end
endmodule

// File: rtl/sem_bank_cmd.sv
module sem_bank_cmd
  import sbu_pkg::*;
#(
  parameter int NSEM = 32,
  parameter int VW   = 12,
  localparam int IW  = $clog2(NSEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              cmd_phase_pre,
  output logic              cmd_ready,
  output logic              cmd_err,
  input  logic              wl_valid,
  input  logic [IW-1:0]     wl_idx,
  input  logic              wl_down,
  input  logic [IW-1:0]     rd_idx,
  output logic [VW-1:0]     rd_value
);
  logic          dec_active;
  sem_op_e       dec_op;
  logic [IW-1:0] dec_idx;
  logic [VW-1:0] dec_val;
  logic [VW-1:0] cur;
  logic          ev_apply;
  logic          ev_load;
  logic [VW-1:0] ev_delta;
  logic          ev_err;
  logic [NSEM*VW-1:0] sem_flat;

  sbu_decode #(.IW(IW), .VW(VW)) u_dec (
    .word(cmd_word), .phase_pre(cmd_phase_pre), .active(dec_active),
    .op(dec_op), .idx(dec_idx), .val(dec_val)
  );

  sbu_eval #(.VW(VW)) u_eval (
    .valid(cmd_valid), .active(dec_active), .op(dec_op), .cur(cur),
    .val(dec_val), .ready(cmd_ready), .apply(ev_apply), .load(ev_load),
    .delta(ev_delta), .err(ev_err)
  );

  sbu_store #(.NSEM(NSEM), .VW(VW)) u_store (
    .clk(clk), .rst(rst), .c_apply(ev_apply), .c_idx(dec_idx),
    .c_load(ev_load), .c_val(dec_val), .c_delta(ev_delta),
    .w_valid(wl_valid), .w_idx(wl_idx), .w_down(wl_down),
    .rd_idx(rd_idx), .c_cur(cur), .sem_flat(sem_flat), .rd_value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= ev_err;
  end

  // Checks across decode, evaluation and storage
  logic [VW-1:0] sem_view [NSEM];
  for (genvar i = 0; i < NSEM; i++) begin : g_view
    assign sem_view[i] = sem_flat[i*VW +: VW];
  end

  logic hs, wl_same;
  assign hs      = cmd_valid && cmd_ready;
  assign wl_same = wl_valid && (wl_idx == dec_idx);

  a_r8_take_nonzero: assert property (@(posedge clk) disable iff (rst)
    (hs && dec_active && dec_op == OP_TAKE) |-> (cur != '0));

  a_r8_take_dec: assert property (@(posedge clk) disable iff (rst)
    (hs && dec_active && dec_op == OP_TAKE && !wl_same)
    |=> (sem_view[$past(dec_idx)] == VW'($past(cur) - VW'(1))));

  a_r4_load_val: assert property (@(posedge clk) disable iff (rst)
    (hs && dec_active && dec_op == OP_LOAD && !wl_same)
    |=> (sem_view[$past(dec_idx)] == $past(dec_val)));

  a_r2_skip_keeps: assert property (@(posedge clk) disable iff (rst)
    (hs && !dec_active && !wl_same)
    |=> (sem_view[$past(dec_idx)] == $past(cur)));

  a_r9_err_origin: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(hs && dec_active && dec_op == OP_RSV));

  a_r11_both_inc: assert property (@(posedge clk) disable iff (rst)
    (hs && dec_active && dec_op == OP_INC && wl_same && !wl_down)
    |=> (sem_view[$past(dec_idx)] == VW'($past(cur) + VW'(2))));
endmodule

// File: tb/sem_bank_cmd_test.sv
module sem_bank_cmd_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_phase_pre = 1'b0;
  logic        cmd_ready;
  logic        cmd_err;
  logic        wl_valid = 1'b0;
  logic [4:0]  wl_idx = '0;
  logic        wl_down = 1'b0;
  logic [4:0]  rd_idx = '0;
  logic [11:0] rd_value;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sem_bank_cmd uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_phase_pre(cmd_phase_pre), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
    .wl_valid(wl_valid), .wl_idx(wl_idx), .wl_down(wl_down),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  function automatic logic [31:0] mk(bit en, int op, bit pre, int idx, int val);
    return {en, 4'b0, 3'(op), 1'b0, pre, 1'b0, 5'(idx), 4'b0, 12'(val)};
  endfunction

  task automatic chk(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue a command that is expected to complete at once.
  task automatic issue(logic [31:0] w, string tag);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    #1 chk(cmd_ready, 1, tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(int idx, output int v);
    @(negedge clk);
    rd_idx = 5'(idx);
    @(negedge clk);
    v = rd_value;
  endtask

  task automatic t_reset;
    int v;
    chk(cmd_err, 0, "R1 err");
    rd(0, v);  chk(v, 0, "R1 sem0");
    rd(31, v); chk(v, 0, "R1 sem31");
  endtask

  task automatic t_load_skip;
    int v;
    issue(mk(1, 1, 0, 3, 321), "R4 ready");
    rd(3, v); chk(v, 321, "R4 load");
    issue(mk(0, 1, 0, 3, 55), "R2 ready");
    rd(3, v); chk(v, 321, "R2 unchanged");
    issue(mk(1, 1, 1, 3, 77), "R3 ready");
    rd(3, v); chk(v, 321, "R3 unchanged");
    cmd_phase_pre = 1'b1;
    issue(mk(1, 2, 1, 3, 0), "R3 pre ready");
    rd(3, v); chk(v, 322, "R3 pre applied");
    cmd_phase_pre = 1'b0;
  endtask

  task automatic t_wrap;
    int v;
    issue(mk(1, 1, 0, 1, 4095), "R5 load");
    issue(mk(1, 2, 0, 1, 0), "R5 inc");
    rd(1, v); chk(v, 0, "R5 wrap up");
    issue(mk(1, 3, 0, 1, 0), "R5 dec");
    rd(1, v); chk(v, 4095, "R5 wrap down");
  endtask

  task automatic t_wl;
    int v;
    @(negedge clk);
    wl_valid = 1'b1; wl_idx = 5'd30; wl_down = 1'b1;
    @(negedge clk);
    wl_valid = 1'b0;
    rd(30, v); chk(v, 4095, "R10 wl down");
    @(negedge clk);
    wl_valid = 1'b1; wl_down = 1'b0;
    @(negedge clk);
    wl_valid = 1'b0;
    rd(30, v); chk(v, 0, "R10 wl up");
  endtask

  task automatic t_weq;
    int v;
    issue(mk(1, 1, 0, 7, 5), "R6 load");
    @(negedge clk);
    cmd_word = mk(1, 4, 0, 7, 6); cmd_valid = 1'b1;
    wl_valid = 1'b1; wl_idx = 5'd7; wl_down = 1'b0;
    #1 chk(cmd_ready, 0, "R6 blocked");
    @(negedge clk);
    wl_valid = 1'b0;
    #1 chk(cmd_ready, 1, "R6 released");
    @(negedge clk);
    cmd_valid = 1'b0;
    rd(7, v); chk(v, 6, "R6 unchanged");
  endtask

  task automatic t_wge;
    issue(mk(1, 1, 0, 9, 10), "R7 load");
    issue(mk(1, 5, 0, 9, 10), "R7 equal ok");
    @(negedge clk);
    cmd_word = mk(1, 5, 0, 9, 11); cmd_valid = 1'b1;
    #1 chk(cmd_ready, 0, "R7 below blocked");
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_take;
    int v;
    @(negedge clk);
    cmd_word = mk(1, 6, 0, 2, 0); cmd_valid = 1'b1;
    #1 chk(cmd_ready, 0, "R8 zero blocked");
    @(negedge clk);
    #1 chk(cmd_ready, 0, "R8 still blocked");
    wl_valid = 1'b1; wl_idx = 5'd2; wl_down = 1'b0;
    @(negedge clk);
    wl_valid = 1'b0;
    #1 chk(cmd_ready, 1, "R8 released");
    @(negedge clk);
    cmd_valid = 1'b0;
    rd(2, v); chk(v, 0, "R8 taken");
    issue(mk(1, 1, 0, 2, 3), "R8 load");
    issue(mk(1, 6, 0, 2, 0), "R8 take3");
    rd(2, v); chk(v, 2, "R8 dec");
  endtask

  task automatic t_rsv;
    int v;
    issue(mk(1, 1, 0, 4, 40), "R9 load");
    @(negedge clk);
    cmd_word = mk(1, 7, 0, 4, 99); cmd_valid = 1'b1;
    #1 chk(cmd_ready, 1, "R9 ready");
    chk(cmd_err, 0, "R9 err before");
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err, 1, "R9 err pulse");
    @(negedge clk);
    chk(cmd_err, 0, "R9 err drop");
    rd(4, v); chk(v, 40, "R9 unchanged");
    issue(mk(1, 0, 0, 4, 7), "R9 nop");
    chk(cmd_err, 0, "R9 nop no err");
    rd(4, v); chk(v, 40, "R9 nop unchanged");
  endtask

  task automatic t_collide;
    int v;
    @(negedge clk);
    cmd_word = mk(1, 1, 0, 12, 100); cmd_valid = 1'b1;
    wl_valid = 1'b1; wl_idx = 5'd12; wl_down = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0; wl_valid = 1'b0;
    rd(12, v); chk(v, 101, "R11 load+wl");
    @(negedge clk);
    cmd_word = mk(1, 2, 0, 12, 0); cmd_valid = 1'b1;
    wl_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; wl_valid = 1'b0;
    rd(12, v); chk(v, 103, "R11 inc+inc");
    issue(mk(1, 1, 0, 13, 1), "R11 load1");
    @(negedge clk);
    cmd_word = mk(1, 6, 0, 13, 0); cmd_valid = 1'b1;
    wl_valid = 1'b1; wl_idx = 5'd13;
    #1 chk(cmd_ready, 1, "R11 take ready");
    @(negedge clk);
    cmd_valid = 1'b0; wl_valid = 1'b0;
    rd(13, v); chk(v, 1, "R11 take+wl");
  endtask

  task automatic t_read;
    int v;
    rd(12, v); chk(v, 103, "R12 read a");
    @(negedge clk);
    rd_idx = 5'd9;
    #1 chk(rd_value, 103, "R12 still old");
    @(negedge clk);
    chk(rd_value, 10, "R12 new");
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_skip();
    t_wrap();
    t_wl();
    t_weq();
    t_wge();
    t_take();
    t_rsv();
    t_collide();
    t_read();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end
endmodule